// File: doc/BRIEF.md
# Port-Programmed Sprite Blitter

This block copies rectangles between ordinary memory and a one-byte-per-pixel frame buffer. Software drives it through two byte-wide write ports. A write to the control port can open a settings phase. During that phase, six writes to the settings port stream in a 16-bit linear address and then the rectangle's x, y, width and height. A later control write starts a transfer in one of two directions. The settings are kept, so the same rectangle can be drawn again with a single control write.

In the draw direction, the linear address is the source. Each byte is masked down to a 4-bit colour index before it is stored. An optional rule leaves pixels untouched when the source byte has its top bit set. In the capture direction, frame-buffer bytes are copied unchanged to the linear address. Pixels that fall outside the frame buffer are clipped, but they still use their place in the linear stream. The block masters a single byte-wide memory port and raises `busy` while a transfer runs.

Top module: `sprite_blitter`

## Requirements
- R1: A port read returns the port number on `io_rdata` when `io_addr` equals the control port (default 0xB0) or the settings port (default 0xB1), and 0x00 for any other address.
- R2: A control write with bit 7 set enters settings mode. The next six settings-port writes load, in this order: address low byte, address high byte, x, y, width and height. Further settings writes, and settings writes made outside settings mode, have no effect.
- R3: A control write with bit 0 set and bit 7 clear draws. For pixel (c, r), taken row by row, the block reads source address `addr + r*width + c` in one cycle. In the next cycle it writes frame-buffer address `FB_BASE + (y+r)*FB_W + (x+c)`. Read data is taken one cycle after `mem_rd`.
- R4: A drawn byte is the low nibble of the source (bits 3:0), with bits 7:4 of `mem_wdata` at zero, so no index above 15 reaches the frame buffer.
- R5: When control bit 1 is set during a draw, a source byte with bit 7 set produces no write cycle. The pixel still takes its read cycle and its store cycle.
- R6: A control write with bit 2 set and bit 0 clear captures. Each frame-buffer byte is read, then written unchanged to `addr + r*width + c` in the next cycle. If bits 0 and 2 are both set, the block draws.
- R7: A pixel with x+c ≥ FB_W or y+r ≥ FB_H takes one idle cycle with no memory access, and its linear address is skipped.
- R8: A start command with zero width or zero height causes no memory access, and `busy` stays low.
- R9: `busy` rises in the cycle after the start command and falls in the cycle after the last pixel's final cycle. Control writes made while `busy` is high are ignored.
- R10: Settings persist across transfers: a second start command without a new settings phase repeats the same rectangle.
- R11: `mem_rd` and `mem_wr` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Port write strobe |
| io_addr | input | 8 | Port number |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read value (echoes own port numbers) |
| busy | output | 1 | Transfer in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd` |

## Verification
The bench builds the block with a 16x16 frame buffer (FB_W = FB_H = 16) and keeps the default base of 0xBF00 and the default port numbers. The small frame buffer lets a 4x3 sprite placed at (14, 14) cross both the right and the bottom edge. Clipping, skipped source addresses and row wrap are therefore all exercised in a few dozen cycles. The same small grid keeps the full expected bus trace short enough to compare on every cycle of every transfer.

// File: rtl/sprite_blitter.sv
module sprite_blitter #(
  parameter logic [7:0]  CTRL_PORT = 8'hB0,
  parameter logic [7:0]  SET_PORT  = 8'hB1,
  parameter logic [15:0] FB_BASE   = 16'hBF00,
  parameter int          FB_W      = 128,
  parameter int          FB_H      = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic [7:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        busy,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  localparam logic [9:0]  W_LIM   = 10'(FB_W);
  localparam logic [9:0]  H_LIM   = 10'(FB_H);
  localparam logic [15:0] ROW_LEN = 16'(FB_W);

  typedef enum logic [1:0] {IDLE, FETCH, STORE} state_t;
  state_t state;

  logic        set_mode;
  logic [2:0]  set_idx;
  logic [15:0] s_addr;
  logic [7:0]  s_x, s_y, s_w, s_h;
  logic        dir_wr, trans;
  logic [7:0]  col, row;
  logic [15:0] ptr;

  logic [8:0]  ax, ay;
  logic [15:0] row_off, fb_addr;
  logic        visible, last_px, step, ctl_hit, set_hit, start_ok;

  assign ax       = 9'(s_x) + 9'(col);
  assign ay       = 9'(s_y) + 9'(row);
  assign row_off  = 16'({7'd0, ay}) * ROW_LEN;
  assign fb_addr  = FB_BASE + row_off + 16'(ax);
  assign visible  = ({1'b0, ax} < W_LIM) && ({1'b0, ay} < H_LIM);
  assign last_px  = (col == s_w - 8'd1) && (row == s_h - 8'd1);
  assign step     = (state == STORE) || (state == FETCH && !visible);
  assign ctl_hit  = io_wr && io_addr == CTRL_PORT;
  assign set_hit  = io_wr && io_addr == SET_PORT;
  assign start_ok = !io_wdata[7] && (io_wdata[0] || io_wdata[2]) &&
                    s_w != 8'd0 && s_h != 8'd0;

  assign io_rdata  = (io_addr == CTRL_PORT || io_addr == SET_PORT) ? io_addr : 8'h00;
  assign busy      = state != IDLE;
  assign mem_rd    = state == FETCH && visible;
  assign mem_wr    = state == STORE && !(dir_wr && trans && mem_rdata[7]);
  assign mem_addr  = ((state == FETCH) == dir_wr) ? ptr : fb_addr;
  assign mem_wdata = dir_wr ? {4'h0, mem_rdata[3:0]} : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      set_mode <= 1'b0;
      set_idx  <= '0;
      s_addr   <= '0;
      s_x      <= '0;
      s_y      <= '0;
      s_w      <= '0;
      s_h      <= '0;
      dir_wr   <= 1'b0;
      trans    <= 1'b0;
      col      <= '0;
      row      <= '0;
      ptr      <= '0;
    end else if (state == IDLE) begin
      if (ctl_hit) begin
        set_mode <= io_wdata[7];
        set_idx  <= '0;
        if (start_ok) begin
          state  <= FETCH;
          dir_wr <= io_wdata[0];
          trans  <= io_wdata[1];
          col    <= '0;
          row    <= '0;
          ptr    <= s_addr;
        end
      end else if (set_hit && set_mode && set_idx < 3'd6) begin
        set_idx <= set_idx + 3'd1;
        case (set_idx)
          3'd0:    s_addr[7:0]  <= io_wdata;
          3'd1:    s_addr[15:8] <= io_wdata;
          3'd2:    s_x          <= io_wdata;
          3'd3:    s_y          <= io_wdata;
          3'd4:    s_w          <= io_wdata;
          default: s_h          <= io_wdata;
        endcase
      end
    end else if (step) begin
      ptr <= ptr + 16'd1;
      if (col == s_w - 8'd1) begin
        col <= '0;
        row <= row + 8'd1;
      end else begin
        col <= col + 8'd1;
      end
      state <= last_px ? IDLE : FETCH;
    end else begin
      state <= STORE;
    end
  end
endmodule

module sprite_blitter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [7:0] mem_wdata,
  input logic [7:0] mem_rdata,
  input logic       dir_wr,
  input logic       trans
);
  AST_STORE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R3
  AST_NIBBLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && dir_wr) |-> mem_wdata[7:4] == 4'h0); // R4
  AST_TRANSPARENT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dir_wr && trans && $past(mem_rd) && mem_rdata[7]) |-> !mem_wr); // R5
  AST_CFG_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(dir_wr) && $stable(trans))); // R9
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R11
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr)); // R11
endmodule

bind sprite_blitter sprite_blitter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dir_wr(dir_wr), .trans(trans)
);

// File: tb/sprite_blitter_test.sv
`timescale 1ns/1ps
module sprite_blitter_test;
  localparam int FBW = 16;
  localparam int FBH = 16;
  localparam int BASE = 'hBF00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic busy, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] mem [0:65535];

  int n_cmp = 0;
  int n_bad = 0;
  int s_addr = 0, s_x = 0, s_y = 0, s_w = 0, s_h = 0;
  int q_kind[$], q_addr[$], q_data[$];

  always #2.5 clk = ~clk;

  sprite_blitter #(.FB_W(FBW), .FB_H(FBH)) uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] = mem_wdata;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr_port(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 8'h00;
  endtask

  task automatic load(input int a, input int x, input int y, input int w, input int h);
    wr_port(8'hB0, 8'h80);
    wr_port(8'hB1, 8'(a)); wr_port(8'hB1, 8'(a >> 8));
    wr_port(8'hB1, 8'(x)); wr_port(8'hB1, 8'(y));
    wr_port(8'hB1, 8'(w)); wr_port(8'hB1, 8'(h));
    s_addr = a; s_x = x; s_y = y; s_w = w; s_h = h;
  endtask

  task automatic build(input int ctl);
    int k = 0;
    q_kind.delete(); q_addr.delete(); q_data.delete();
    if (s_w == 0 || s_h == 0) return;
    for (int r = 0; r < s_h; r++)
      for (int c = 0; c < s_w; c++) begin
        int ax = s_x + c, ay = s_y + r;
        int lin = (s_addr + k) & 'hFFFF;
        int fa = (BASE + ay * FBW + ax) & 'hFFFF;
        if (ax < FBW && ay < FBH) begin
          if (ctl[0]) begin
            int d = mem[lin];
            q_kind.push_back(1); q_addr.push_back(lin); q_data.push_back(0);
            if (ctl[1] && d[7]) begin
              q_kind.push_back(0); q_addr.push_back(0); q_data.push_back(0);
            end else begin
              q_kind.push_back(2); q_addr.push_back(fa); q_data.push_back(d & 15);
            end
          end else begin
            q_kind.push_back(1); q_addr.push_back(fa); q_data.push_back(0);
            q_kind.push_back(2); q_addr.push_back(lin); q_data.push_back(mem[fa]);
          end
        end else begin
          q_kind.push_back(0); q_addr.push_back(0); q_data.push_back(0);
        end
        k++;
      end
  endtask

  task automatic run_draw(input int ctl, input string tag, input int poke);
    build(ctl);
    @(negedge clk);
    io_wr = 1'b1; io_addr = 8'hB0; io_wdata = 8'(ctl);
    @(negedge clk);
    io_wr = 1'b0; io_addr = 8'h00;
    for (int i = 0; i < q_kind.size(); i++) begin
      if (i > 0) begin
        @(negedge clk);
        io_wr = 1'b0; io_addr = 8'h00;
      end
      check({tag, " busy R9"}, busy, 1);
      check({tag, " rd"}, mem_rd, q_kind[i] == 1);
      check({tag, " wr"}, mem_wr, q_kind[i] == 2);
      if (q_kind[i] != 0) check({tag, " addr"}, mem_addr, q_addr[i]);
      if (q_kind[i] == 2) check({tag, " data"}, mem_wdata, q_data[i]);
      if (i == poke) begin
        io_wr = 1'b1; io_addr = 8'hB0; io_wdata = 8'h84;
      end
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      io_wr = 1'b0; io_addr = 8'h00;
      check({tag, " idle R9 R8 R11"}, {busy, mem_rd, mem_wr}, 0);
    end
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    for (int a = 0; a < 65536; a++) mem[a] = 8'h00;
    begin
      int src[12] = '{8'h01, 8'h85, 8'h13, 8'h07, 8'hF2, 8'h0A,
                      8'h80, 8'h3C, 8'h0F, 8'h90, 8'h22, 8'h05};
      for (int i = 0; i < 12; i++) mem['h0100 + i] = 8'(src[i]);
      for (int i = 0; i < 12; i++) mem['h0200 + i] = 8'(i + 1);
    end
    repeat (3) @(negedge clk);
    check("reset R9", {busy, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset R11", {busy, mem_rd, mem_wr}, 0);

    io_addr = 8'hB0; #1; check("echo ctrl R1", io_rdata, 8'hB0);
    io_addr = 8'hB1; #1; check("echo set R1", io_rdata, 8'hB1);
    io_addr = 8'h42; #1; check("echo other R1", io_rdata, 8'h00);
    io_addr = 8'h00;

    load('h0100, 2, 3, 4, 3);
    wr_port(8'hB1, 8'hAA);
    run_draw(1, "draw R3 R2", -1);
    check("mask R4", mem[BASE + 3*FBW + 3], 8'h05);
    check("mask R4", mem[BASE + 4*FBW + 2], 8'h02);

    run_draw(3, "transp R5 R10", -1);
    check("transp keeps R5", mem[BASE + 4*FBW + 4], 8'h00);
    check("repeat R10", mem[BASE + 3*FBW + 2], 8'h01);

    load('h0300, 2, 3, 4, 3);
    run_draw(4, "capture R6", -1);
    check("capture R6", mem['h0301], 8'h05);
    check("capture R6", mem['h0305], 8'h0A);
    run_draw(5, "both bits R6", -1);

    load('h0200, 14, 14, 4, 3);
    run_draw(1, "clip R7", -1);
    check("clip R7", mem[BASE + 15*FBW + 15], 8'h06);
    check("clip R7", mem[BASE + 14*FBW + 14], 8'h01);

    load('h0100, 0, 0, 0, 5);
    run_draw(1, "zero w R8", -1);
    load('h0100, 0, 0, 5, 0);
    run_draw(1, "zero h R8", -1);

    load('h0100, 5, 6, 3, 2);
    run_draw(1, "poke R9", 2);
    wr_port(8'hB1, 8'h55);
    run_draw(1, "after poke R2 R10", -1);

    summary();
  end
endmodule